// File: doc/BRIEF.md
# Timestamp-Indexed Contention Buffer

This block is the contention-packet store of one middle node in a two-stage packet switch. It has a fixed number of entries, W, and W is a power of two. The global time-slot counter `t_now` chooses the entry for arrivals: the entry is `t_now mod W`, which is the low log2 W bits of the counter. An output port reads a packet back by presenting the low log2 W bits of that packet's arrival time on `rd_ts`. The read costs one lookup, whatever the occupancy. The buffer tells the first stage whether the current entry can take a packet. It accepts at most one arrival per slot.

The node also produces two side results. The first is a two-bit report for each slot: whether a packet was received, and whether that packet was a reservation packet. The second is an N-bit blocking vector. The node keeps one occupancy counter per output for its reservation queues, and bit j of the vector is set while the counter for output j is non-zero.

Each entry is a small state machine with two states, SLOT_EMPTY and SLOT_HELD. It has three named transitions:
- FILL goes from SLOT_EMPTY to SLOT_HELD on a write.
- DRAIN goes from SLOT_HELD to SLOT_EMPTY on a read.
- SWAP stays in SLOT_HELD and loads new data, on a read and a write in the same cycle.

In every other case the entry keeps its state.

Top module: `cb_contention_buf`

## Requirements
- R1: The current entry index is `t_now[log2 W - 1:0]`. `cur_free` is 1 in either of two cases: that entry is empty, or a valid read addresses that same entry in the same cycle.
- R2: `wr_ack` is 1 exactly when all three hold: `arr_vld` is 1, `arr_is_res` is 0, and `cur_free` is 1. An accepted packet's `arr_data` is stored in the current entry. A refused packet is dropped and leaves the entry's contents unchanged.
- R3: When `rd_req` addresses a held entry, `rd_vld` is 1 and `rd_data` shows the stored data in the same cycle. The entry is empty after the clock edge.
- R4: A read and an accepted write may address the same entry in the same cycle. The read then returns the old data, and the new data is held after the edge.
- R5: When `rd_req` addresses an empty entry, `rd_err` is 1, `rd_vld` is 0 and `rd_data` is all zeros. A cycle without `rd_req` keeps `rd_vld` and `rd_err` at 0.
- R6: One cycle after an arrival, `msg[1]` says whether a packet was received. A reservation arrival always counts as received; a contention arrival counts only when it was accepted. `msg[0]` is 1 for a reservation arrival. A reservation arrival never touches the contention entries.
- R7: `blk_vec[j]` is 1 exactly while the reservation count for output j is non-zero. `res_push[j]` adds one to that count and `res_pop[j]` removes one. When both are set in the same cycle the count is unchanged. A change shows on `blk_vec` one cycle after the push or pop.
- R8: A pop on a zero count is ignored. A push on a count that is at its maximum, 2**CW-1, is ignored.
- R9: After reset, all entries are empty, all counts are zero and `msg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Active-low synchronous reset |
| t_now | input | TW | Global time-slot counter |
| arr_vld | input | 1 | A packet arrives this slot |
| arr_is_res | input | 1 | The arriving packet is a reservation packet |
| arr_data | input | PW | Payload of the arriving contention packet |
| rd_req | input | 1 | An output asks for a stored packet |
| rd_ts | input | log2 W | Low timestamp bits of the requested packet |
| res_push | input | N | Per-output reservation enqueue strobes |
| res_pop | input | N | Per-output reservation dequeue strobes |
| cur_free | output | 1 | The current entry can take a packet |
| wr_ack | output | 1 | The contention arrival was stored |
| rd_vld | output | 1 | `rd_data` carries a released packet |
| rd_data | output | PW | Released payload, zero when not valid |
| rd_err | output | 1 | The read addressed an empty entry |
| msg | output | 2 | {received, reservation} report for the previous slot |
| blk_vec | output | N | Per-output blocking requests |

## Verification
`cur_free`, `wr_ack`, `rd_vld`, `rd_data` and `rd_err` are combinational. The bench checks them one time unit after it drives the inputs, before the next rising edge. `msg` and `blk_vec` come from registers, so they are due in the cycle after the stimulus. The bench holds the expected `msg` across one edge and checks `blk_vec` against counts it updated at the previous edge. The bench's model of the entries and counts advances only after the checks for the current cycle are done, and in the order the requirements give: the read first, then the write.

// File: rtl/cb_pkg.sv
package cb_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_t;

    typedef struct packed {
        logic got;
        logic is_res;
    } node_msg_t;

endpackage

// File: rtl/cb_slot.sv
module cb_slot
    import cb_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [PW-1:0] wr_data,
    output logic          held,
    output logic [PW-1:0] data
);

    slot_state_t state, state_nxt;
    logic        load;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SLOT_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Payload register; loads only on the FILL or SWAP transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (load) begin
            data <= wr_data;
        end
    end

    // Transitions: FILL, DRAIN, SWAP.
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        unique case (state)
            SLOT_EMPTY: begin
                if (wr_en) begin
                    state_nxt = SLOT_HELD;      // FILL
                    load      = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (rd_en && wr_en) begin
                    state_nxt = SLOT_HELD;      // SWAP
                    load      = 1'b1;
                end else if (rd_en) begin
                    state_nxt = SLOT_EMPTY;     // DRAIN
                end
            end
            default: state_nxt = SLOT_EMPTY;
        endcase
    end

    // Output process.
    always_comb begin
        held = (state == SLOT_HELD);
    end

    AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !wr_en) |=> $stable(data)); // R2

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && wr_en) |-> rd_en); // R2

endmodule

// File: rtl/cb_resv_cnt.sv
module cb_resv_cnt #(
    parameter int CW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic busy
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt;
    logic          do_inc, do_dec;

    always_comb begin
        do_inc = push && !pop && (cnt != CNT_MAX);
        do_dec = pop && !push && (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (do_inc) begin
            cnt <= cnt + 1'b1;
        end else if (do_dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        busy = (cnt != '0);
    end

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !push) |=> !busy); // R8

    AST_CNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push && !pop) |=> busy); // R7

endmodule

// File: rtl/cb_contention_buf.sv
module cb_contention_buf
    import cb_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = 16,
    parameter int N  = 4,
    parameter int TW = 16,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        t_now,
    input  logic                 arr_vld,
    input  logic                 arr_is_res,
    input  logic [PW-1:0]        arr_data,
    input  logic                 rd_req,
    input  logic [$clog2(W)-1:0] rd_ts,
    input  logic [N-1:0]         res_push,
    input  logic [N-1:0]         res_pop,
    output logic                 cur_free,
    output logic                 wr_ack,
    output logic                 rd_vld,
    output logic [PW-1:0]        rd_data,
    output logic                 rd_err,
    output logic [1:0]           msg,
    output logic [N-1:0]         blk_vec
);

    localparam int IW = $clog2(W);

    logic [IW-1:0] idx_w;
    logic [W-1:0]  held;
    logic [W-1:0]  wr_en, rd_en;
    logic [PW-1:0] slot_data [W];
    logic          rd_hit;
    node_msg_t     msg_q, msg_d;

    always_comb begin
        idx_w    = t_now[IW-1:0];
        rd_hit   = rd_req && held[rd_ts];
        rd_vld   = rd_hit;
        rd_err   = rd_req && !held[rd_ts];
        rd_data  = rd_hit ? slot_data[rd_ts] : '0;
        cur_free = !held[idx_w] || (rd_hit && (rd_ts == idx_w));
        wr_ack   = arr_vld && !arr_is_res && cur_free;
        msg_d.got    = arr_vld && (arr_is_res || wr_ack);
        msg_d.is_res = arr_vld && arr_is_res;
    end

    for (genvar k = 0; k < W; k++) begin : g_slot
        always_comb begin
            wr_en[k] = wr_ack && (idx_w == IW'(k));
            rd_en[k] = rd_hit && (rd_ts == IW'(k));
        end

        cb_slot #(.PW(PW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[k]),
            .rd_en   (rd_en[k]),
            .wr_data (arr_data),
            .held    (held[k]),
            .data    (slot_data[k])
        );
    end

    for (genvar j = 0; j < N; j++) begin : g_cnt
        cb_resv_cnt #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (res_push[j]),
            .pop   (res_pop[j]),
            .busy  (blk_vec[j])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else begin
            msg_q <= msg_d;
        end
    end

    always_comb begin
        msg = msg_q;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> held[$past(idx_w)]); // R2

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !(wr_ack && (idx_w == rd_ts))) |=> !held[$past(rd_ts)]); // R3

    AST_RES_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_vld && arr_is_res) |=> (msg == 2'b11)); // R6

    AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_vld && rd_err)); // R5

endmodule

// File: tb/tb_cb_contention_buf.sv
module tb_cb_contention_buf;

    localparam int W  = 8;
    localparam int PW = 16;
    localparam int N  = 4;
    localparam int TW = 16;
    localparam int CW = 3;
    localparam int IW = $clog2(W);
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] t_now = '0;
    logic          arr_vld = 1'b0, arr_is_res = 1'b0;
    logic [PW-1:0] arr_data = '0;
    logic          rd_req = 1'b0;
    logic [IW-1:0] rd_ts = '0;
    logic [N-1:0]  res_push = '0, res_pop = '0;
    logic          cur_free, wr_ack, rd_vld, rd_err;
    logic [PW-1:0] rd_data;
    logic [1:0]    msg;
    logic [N-1:0]  blk_vec;

    always #2.5 clk = ~clk;

    cb_contention_buf #(.W(W), .PW(PW), .N(N), .TW(TW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .t_now(t_now),
        .arr_vld(arr_vld), .arr_is_res(arr_is_res), .arr_data(arr_data),
        .rd_req(rd_req), .rd_ts(rd_ts), .res_push(res_push), .res_pop(res_pop),
        .cur_free(cur_free), .wr_ack(wr_ack), .rd_vld(rd_vld), .rd_data(rd_data),
        .rd_err(rd_err), .msg(msg), .blk_vec(blk_vec)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    bit            m_held [W];
    logic [PW-1:0] m_data [W];
    int            m_cnt  [N];
    logic [1:0]    exp_msg = 2'b00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_blk();
        logic [N-1:0] v;
        for (int j = 0; j < N; j++) v[j] = (m_cnt[j] != 0);
        return v;
    endfunction

    // One time slot: drive, check combinational and registered results, advance model.
    task automatic step(input bit av, input bit ar, input logic [PW-1:0] ad,
                        input bit rq, input logic [IW-1:0] rt,
                        input logic [N-1:0] pu, input logic [N-1:0] po);
        int idx;
        bit hit, free_e, ack_e;
        logic [PW-1:0] dat_e;
        arr_vld = av; arr_is_res = ar; arr_data = ad;
        rd_req = rq; rd_ts = rt; res_push = pu; res_pop = po;
        #1;
        idx    = int'(t_now) % W;
        hit    = rq && m_held[rt];
        free_e = !m_held[idx] || (hit && (int'(rt) == idx));
        ack_e  = av && !ar && free_e;
        dat_e  = hit ? m_data[rt] : '0;
        chk(cur_free == free_e, "R1 cur_free", cur_free, free_e);
        if (hit && (int'(rt) == idx) && av && !ar)
            chk(wr_ack == ack_e, "R4 wr_ack", wr_ack, ack_e);
        else
            chk(wr_ack == ack_e, "R2 wr_ack", wr_ack, ack_e);
        chk(rd_vld == hit, "R3 rd_vld", rd_vld, hit);
        chk(rd_data == dat_e, "R3 rd_data", rd_data, dat_e);
        chk(rd_err == (rq && !hit), "R5 rd_err", rd_err, rq && !hit);
        chk(msg == exp_msg, "R6 msg", msg, exp_msg);
        chk(blk_vec == exp_blk(), "R7 blk_vec", blk_vec, exp_blk());
        // Model update: read first, then write.
        if (hit) m_held[rt] = 1'b0;
        if (ack_e) begin
            m_held[idx] = 1'b1;
            m_data[idx] = ad;
        end
        for (int j = 0; j < N; j++) begin
            if (pu[j] && !po[j] && m_cnt[j] < CMAX) m_cnt[j]++;
            else if (po[j] && !pu[j] && m_cnt[j] > 0) m_cnt[j]--;
        end
        exp_msg = {av && (ar || ack_e), av && ar};
        @(posedge clk);
        @(negedge clk);
        t_now = t_now + 1'b1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, 1'b0, '0, '0, '0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < W; k++) begin m_held[k] = 1'b0; m_data[k] = '0; end
        for (int j = 0; j < N; j++) m_cnt[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(cur_free == 1'b1, "R9 cur_free", cur_free, 1);
        chk(msg == 2'b00, "R9 msg", msg, 0);
        chk(blk_vec == '0, "R9 blk_vec", blk_vec, 0);

        // R2: fill entry 0, then a refused write to the same entry one lap later
        step(1'b1, 1'b0, 16'hA5A5, 1'b0, '0, '0, '0);
        repeat (W - 1) idle();
        step(1'b1, 1'b0, 16'h1111, 1'b0, '0, '0, '0);
        // R3: read back the original payload
        step(1'b0, 1'b0, '0, 1'b1, 3'd0, '0, '0);
        // R5: read of the now empty entry
        step(1'b0, 1'b0, '0, 1'b1, 3'd0, '0, '0);
        // R4: fill entry at t=W+3 (idx 3), later read+write on idx 3 in one slot
        while (int'(t_now) % W != 3) idle();
        step(1'b1, 1'b0, 16'hBEEF, 1'b0, '0, '0, '0);
        repeat (W - 1) idle();
        step(1'b1, 1'b0, 16'hCAFE, 1'b1, 3'd3, '0, '0);
        step(1'b0, 1'b0, '0, 1'b1, 3'd3, '0, '0);
        // R6: reservation arrival leaves the contention entry empty
        step(1'b1, 1'b1, 16'hFFFF, 1'b0, '0, '0, '0);
        step(1'b0, 1'b0, '0, 1'b1, IW'(int'(t_now - 1'b1) % W), '0, '0);

        // R8: pop at zero, then saturating pushes
        step(1'b0, 1'b0, '0, 1'b0, '0, '0, 4'b0001);
        idle();
        chk(blk_vec[0] == 1'b0, "R8 pop at zero", blk_vec[0], 0);
        repeat (CMAX + 2) step(1'b0, 1'b0, '0, 1'b0, '0, 4'b0001, '0);
        repeat (CMAX) step(1'b0, 1'b0, '0, 1'b0, '0, '0, 4'b0001);
        idle();
        chk(blk_vec[0] == 1'b0, "R8 saturated count drains", blk_vec[0], 0);

        // Constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            bit av, ar, rq;
            logic [IW-1:0] rt;
            logic [N-1:0] pu, po;
            av = ($urandom % 100) < 55;
            ar = ($urandom % 100) < 25;
            rq = ($urandom % 100) < 40;
            rt = IW'($urandom % W);
            for (int j = 0; j < N; j++) begin
                pu[j] = ($urandom % 100) < 20;
                po[j] = ($urandom % 100) < 22;
            end
            step(av, ar, PW'($urandom), rq, rt, pu, po);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule